// File: doc/BRIEF.md
# Training-Set Lane Polarity Detector

This block sits on one receive lane, in front of the 8b/10b decoder. It watches decoded symbols of incoming training ordered sets and decides whether the lane's differential pair is wired swapped. A swapped pair turns each identifier symbol of a training set into a different data symbol.

The first ordered-set kind (`os_type_i = 2'b01`) normally carries 0x4A in its identifier field. It carries 0xB5 when the pair is swapped. The second kind (`os_type_i = 2'b10`) normally carries 0x45, and 0xBA when swapped. The identifier field covers symbol indices 6 to 15 of the set.

When one complete set shows the swapped identifier in all ten positions, a sticky flag is raised. From then on, every raw 10-bit code group is complemented on its way to the decoder. The flag stays set until the clear input re-arms detection, or until reset. Symbol alignment, decoding and training control are done elsewhere.

Top module: `pol_inv_detect`

## Requirements
- R1: After reset `inv_o` is 0 and `code_o` equals `raw_code_i`.
- R2: When `os_type_i = 2'b01` and indices 6 to 15 all carry data (not control) symbol 0xB5 with `sym_valid_i` high, `inv_o` becomes 1 on the clock edge that takes index 15.
- R3: When `os_type_i = 2'b10` and indices 6 to 15 all carry data symbol 0xBA, `inv_o` becomes 1 on the clock edge that takes index 15.
- R4: A set whose identifier is any value other than the swapped one for its type leaves `inv_o` at 0. This includes the normal identifiers 0x4A and 0x45, and the swapped identifier of the other type.
- R5: A set in which any one of the ten identifier positions does not match leaves `inv_o` at 0. Such a set also does not clear a flag that is already set.
- R6: Symbols at indices 0 to 5, symbols with `os_type_i` of 2'b00 or 2'b11, and symbols with `sym_valid_i` low never contribute to setting the flag.
- R7: Once set, `inv_o` holds until `clr_i` is high on a clock edge. After that edge `inv_o` is 0, and `clr_i` wins over a set in the same cycle.
- R8: `code_o` equals `raw_code_i` with all ten bits complemented when `inv_o` is 1, and equals `raw_code_i` unchanged otherwise. It responds combinationally in the same cycle.
- R9: A control symbol (`sym_is_k_i` high) never counts as a swapped identifier, even when its byte value matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Clears the flag and re-arms detection |
| sym_valid_i | input | 1 | Decoded symbol below is valid this cycle |
| os_type_i | input | 2 | Ordered-set kind: 01 first training kind, 10 second, others not training |
| sym_idx_i | input | 4 | Symbol position within the ordered set |
| sym_data_i | input | 8 | Decoded symbol byte |
| sym_is_k_i | input | 1 | Decoded symbol is a control symbol |
| raw_code_i | input | 10 | Raw code group from the deserializer |
| code_o | output | 10 | Raw code group after polarity correction |
| inv_o | output | 1 | Latched lane-polarity-swapped flag |

## Verification
Each training kind is driven with full identifier fields of every possible byte value. Only the one swapped value per kind may set the flag, so this separates a correct comparison from a swapped constant or a type mix-up. Sets with a single bad symbol at each of the ten positions show whether every position is really required. Sets with the swapped pattern only in indices 0 to 5, with a non-training type, with control symbols, or with valid low show that these inputs are ignored. The full 1024-value raw code sweep, run with the flag in each state, shows that correction covers every bit.

// File: rtl/pol_pkg.sv
package pol_pkg;
   typedef enum logic [1:0] {
      OS_OTHER = 2'b00,
      OS_TS_A  = 2'b01,
      OS_TS_B  = 2'b10,
      OS_RSVD  = 2'b11
   } os_kind_e;

   localparam logic [7:0] TS_A_SWAPPED = 8'hB5;
   localparam logic [7:0] TS_B_SWAPPED = 8'hBA;
endpackage

// File: rtl/pol_match.sv
module pol_match
   import pol_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] SWAP_A = DATA_W'(TS_A_SWAPPED),
   parameter logic [DATA_W-1:0] SWAP_B = DATA_W'(TS_B_SWAPPED)
) (
   input  logic              valid_i,
   input  logic [1:0]        kind_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              is_k_i,
   output logic              hit_o
);
   logic is_a, is_b;

   always_comb begin
      is_a  = (kind_i == 2'(OS_TS_A)) && (data_i == SWAP_A);
      is_b  = (kind_i == 2'(OS_TS_B)) && (data_i == SWAP_B);
      hit_o = valid_i && !is_k_i && (is_a || is_b);
   end
endmodule

// File: rtl/pol_tracker.sv
module pol_tracker
   import pol_pkg::*;
#(
   parameter int IDX_W     = 4,
   parameter int FIRST_IDX = 6,
   parameter int LAST_IDX  = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             valid_i,
   input  logic [1:0]       kind_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             is_k_i,
   input  logic             hit_i,
   output logic             inv_o
);
   localparam int RUN_LEN = LAST_IDX - FIRST_IDX + 1;
   localparam int CNT_W   = $clog2(RUN_LEN + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             in_win, is_train, at_first, at_last, set_now;

   always_comb begin
      is_train = (kind_i == 2'(OS_TS_A)) || (kind_i == 2'(OS_TS_B));
      at_first = (idx_i == IDX_W'(FIRST_IDX));
      at_last  = (idx_i == IDX_W'(LAST_IDX));
      in_win   = valid_i && is_train &&
                 (idx_i >= IDX_W'(FIRST_IDX)) && (idx_i <= IDX_W'(LAST_IDX));
      set_now  = in_win && at_last && hit_i && (cnt_q == CNT_W'(RUN_LEN - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         inv_o <= 1'b0;
      end else begin
         if (clr_i) begin
            cnt_q <= '0;
         end else if (in_win) begin
            if (at_first) cnt_q <= CNT_W'(hit_i);
            else          cnt_q <= cnt_q + CNT_W'(hit_i);
         end
         if (clr_i)        inv_o <= 1'b0;
         else if (set_now) inv_o <= 1'b1;
      end
   end

   p_rose_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inv_o) |-> $past(valid_i && at_last && !clr_i));
   p_rose_train_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inv_o) |-> $past(is_train));
   p_rose_not_k_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inv_o) |-> $past(!is_k_i));
   p_clr_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !inv_o);
   p_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_o && !clr_i) |=> inv_o);
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(RUN_LEN));
endmodule

// File: rtl/pol_apply.sv
module pol_apply #(
   parameter int CODE_W = 10
) (
   input  logic              inv_i,
   input  logic [CODE_W-1:0] raw_i,
   output logic [CODE_W-1:0] code_o
);
   for (genvar gi = 0; gi < CODE_W; gi++) begin : g_bit
      assign code_o[gi] = raw_i[gi] ^ inv_i;
   end
endmodule

// File: rtl/pol_inv_detect.sv
module pol_inv_detect
   import pol_pkg::*;
#(
   parameter int CODE_W    = 10,
   parameter int DATA_W    = 8,
   parameter int IDX_W     = 4,
   parameter int FIRST_IDX = 6,
   parameter int LAST_IDX  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              sym_valid_i,
   input  logic [1:0]        os_type_i,
   input  logic [IDX_W-1:0]  sym_idx_i,
   input  logic [DATA_W-1:0] sym_data_i,
   input  logic              sym_is_k_i,
   input  logic [CODE_W-1:0] raw_code_i,
   output logic [CODE_W-1:0] code_o,
   output logic              inv_o
);
   if (LAST_IDX < FIRST_IDX) begin : g_bad_window
      $error("identifier window is empty");
   end
   if (LAST_IDX >= (1 << IDX_W)) begin : g_bad_idx
      $error("index width too small for identifier window");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("symbol byte narrower than identifier");
   end

   logic hit;

   pol_match #(.DATA_W(DATA_W)) u_match (
      .valid_i (sym_valid_i),
      .kind_i  (os_type_i),
      .data_i  (sym_data_i),
      .is_k_i  (sym_is_k_i),
      .hit_o   (hit)
   );

   pol_tracker #(
      .IDX_W     (IDX_W),
      .FIRST_IDX (FIRST_IDX),
      .LAST_IDX  (LAST_IDX)
   ) u_tracker (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr_i),
      .valid_i (sym_valid_i),
      .kind_i  (os_type_i),
      .idx_i   (sym_idx_i),
      .is_k_i  (sym_is_k_i),
      .hit_i   (hit),
      .inv_o   (inv_o)
   );

   pol_apply #(.CODE_W(CODE_W)) u_apply (
      .inv_i  (inv_o),
      .raw_i  (raw_code_i),
      .code_o (code_o)
   );
endmodule

// File: tb/pol_inv_detect_bench.sv
module pol_inv_detect_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0;
   logic       vld = 1'b0;
   logic [1:0] typ = 2'b00;
   logic [3:0] idx = 4'd0;
   logic [7:0] dat = 8'h00;
   logic       isk = 1'b0;
   logic [9:0] raw = 10'h000;
   logic [9:0] code;
   logic       inv;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pol_inv_detect u_pol_inv_detect (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .sym_valid_i(vld),
      .os_type_i(typ), .sym_idx_i(idx), .sym_data_i(dat),
      .sym_is_k_i(isk), .raw_code_i(raw), .code_o(code), .inv_o(inv));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   // Drive one 16-symbol set; leaves the bench at the negedge after index 15.
   task automatic send_set(input logic [1:0] t, input logic [7:0] lo, input logic [7:0] d,
                           input int bad, input logic k, input logic v, input logic clr_last);
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         vld = v; typ = t; idx = 4'(i); isk = k;
         dat = (i < 6) ? lo : ((i == bad) ? 8'h00 : d);
         clr = (i == 15) ? clr_last : 1'b0;
      end
      @(negedge clk);
      vld = 1'b0; clr = 1'b0; typ = 2'b00; isk = 1'b0;
   endtask

   function automatic logic [7:0] swp(input logic [1:0] t);
      return (t == 2'b01) ? 8'hB5 : 8'hBA;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      raw = 10'h155; #1;
      chk("R1 flag after reset", inv, 0);
      chk("R1 code after reset", code, 10'h155);

      // R8: pass-through sweep with flag clear
      for (int r = 0; r < 1024; r++) begin
         raw = 10'(r); #1;
         chk("R8 no inversion", code, r);
      end

      // R2 R3 R4: every identifier byte for both training kinds
      for (int t = 1; t <= 2; t++) begin
         for (int d = 0; d < 256; d++) begin
            pulse_clr();
            send_set(2'(t), 8'h00, 8'(d), -1, 1'b0, 1'b1, 1'b0);
            if (8'(d) == swp(2'(t)))
               chk((t == 1) ? "R2 swapped set" : "R3 swapped set", inv, 1);
            else
               chk("R4 non-swapped identifier", inv, 0);
         end
      end

      // R5: one mismatching position
      for (int t = 1; t <= 2; t++) begin
         for (int p = 6; p <= 15; p++) begin
            pulse_clr();
            send_set(2'(t), 8'h00, swp(2'(t)), p, 1'b0, 1'b1, 1'b0);
            chk("R5 mixed set", inv, 0);
         end
      end

      // R5: mixed or normal set does not clear
      pulse_clr();
      send_set(2'b01, 8'h00, 8'hB5, -1, 1'b0, 1'b1, 1'b0);
      chk("R2 set before hold", inv, 1);
      send_set(2'b01, 8'h00, 8'hB5, 9, 1'b0, 1'b1, 1'b0);
      chk("R5 mixed keeps flag", inv, 1);
      send_set(2'b10, 8'h00, 8'h45, -1, 1'b0, 1'b1, 1'b0);
      chk("R5 normal keeps flag", inv, 1);

      // R7: holds while idle, then clears
      repeat (5) @(negedge clk);
      chk("R7 hold", inv, 1);

      // R8: complement sweep with flag set
      for (int r = 0; r < 1024; r++) begin
         raw = 10'(r); #1;
         chk("R8 inversion", code, (~r) & 10'h3FF);
      end

      pulse_clr();
      chk("R7 cleared", inv, 0);

      // R7: clear wins over same-cycle set
      send_set(2'b10, 8'h00, 8'hBA, -1, 1'b0, 1'b1, 1'b1);
      chk("R7 clear priority", inv, 0);

      // R6: ignored inputs
      send_set(2'b00, 8'hB5, 8'hB5, -1, 1'b0, 1'b1, 1'b0);
      chk("R6 other type", inv, 0);
      send_set(2'b11, 8'hBA, 8'hBA, -1, 1'b0, 1'b1, 1'b0);
      chk("R6 reserved type", inv, 0);
      send_set(2'b01, 8'hB5, 8'h4A, -1, 1'b0, 1'b1, 1'b0);
      chk("R6 low indices", inv, 0);
      send_set(2'b01, 8'hB5, 8'hB5, -1, 1'b0, 1'b0, 1'b0);
      chk("R6 valid low", inv, 0);

      // R9: control symbols never count
      send_set(2'b01, 8'h00, 8'hB5, -1, 1'b1, 1'b1, 1'b0);
      chk("R9 control symbols", inv, 0);
      send_set(2'b10, 8'h00, 8'hBA, -1, 1'b1, 1'b1, 1'b0);
      chk("R9 control symbols", inv, 0);

      // detection re-arms after clear
      send_set(2'b10, 8'h00, 8'hBA, -1, 1'b0, 1'b1, 1'b0);
      chk("R3 re-armed", inv, 1);

      summary();
   end
endmodule